// File: doc/BRIEF.md
# Lockable Cache Way Victim Selector

This block decides which way of a 16-way set-associative data cache receives a new line after a miss. For each request it sees the indexed set: the valid and dirty bit of every way, and the hit vector from tag compare. It also sees a per-way lockout mask and three policy controls. These are a global cache-off switch, a switch that sends clean displaced lines to a next-level victim cache, and a switch that keeps clean lines in locked ways out of that victim cache.

For ordinary load/store misses, locked ways are never chosen. If every way is locked, nothing is allocated, but hits are still reported. A second request kind, the prefetch fill, places lines only in the locked ways. This lets the lockout mask split the cache into prefetched and demand ways. Among eligible ways, the lowest-numbered invalid way is used first. If all eligible ways are valid, a round-robin pointer chooses one. The block then states whether the displaced line needs a write-back, a clean eviction, or nothing.

Requests use a valid/ready handshake. The registered result is presented for exactly one cycle after acceptance.

Top module: `victim_way_picker`

## Requirements
- R1: `reqReady` is low in reset and high from the first clock after reset release. A request is accepted when `reqValid` and `reqReady` are both high at a clock edge. `respValid` is high in exactly the cycle after each acceptance. While `respValid` is low, every other result output is 0.
- R2: Reset clears all outputs and sets the round-robin pointer to way 0.
- R3: For a load/store request (`fillKind`=0), no way whose `lockMask` bit is 1 is ever chosen. `victimOneHot` has exactly one bit set when `allocEn` is 1, and is 0 otherwise.
- R4: If all 16 `lockMask` bits are 1 on a load/store request, `allocEn` is 0. `respHit` still reports 1 whenever `hitVec` is nonzero.
- R5: With `cacheOff`=1, the result has `forcedMiss`=1, `respHit`=0, `allocEn`=0, `wbReq`=0 and `evictReq`=0, and the round-robin pointer does not move.
- R6: Among eligible ways, the lowest-numbered way with valid=0 is chosen first. Filling an invalid way gives `wbReq`=0 and `evictReq`=0.
- R7: If every eligible way is valid, the victim is the first eligible way at or after the pointer, counting upward with wrap from 15 to 0. After any allocation the pointer becomes victim+1 mod 16. Without an allocation the pointer does not change.
- R8: A displaced dirty line gives `wbReq`=1 and `evictReq`=0, whatever the policy bits are.
- R9: A displaced clean line with `evictClean`=0 gives `wbReq`=0 and `evictReq`=0.
- R10: A displaced clean line with `evictClean`=1 gives `evictReq`=1, unless R11 applies.
- R11: With `keepLockedClean`=1, a displaced clean line in a way whose `lockMask` bit is 1 gives `evictReq`=0 even when `evictClean`=1.
- R12: A prefetch fill (`fillKind`=1) treats only the ways with `lockMask` bit 1 as eligible. If the mask is empty, it allocates nothing.
- R13: If `hitVec` is nonzero and `cacheOff`=0, `respHit` is 1 and nothing is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Miss-handling request present |
| reqReady | output | 1 | Block can accept a request |
| fillKind | input | 1 | 0 = load/store, 1 = prefetch fill |
| cacheOff | input | 1 | Global disable: force miss, change nothing |
| evictClean | input | 1 | Send clean displaced lines to next level |
| keepLockedClean | input | 1 | Drop clean displaced lines from locked ways |
| lockMask | input | 16 | Per-way lockout |
| wayValid | input | 16 | Valid bits of the indexed set |
| wayDirty | input | 16 | Dirty bits of the indexed set |
| hitVec | input | 16 | Tag-compare hit vector |
| respValid | output | 1 | Result valid (one cycle) |
| allocEn | output | 1 | A way is being allocated |
| victimOneHot | output | 16 | Chosen way, one-hot |
| wbReq | output | 1 | Displaced line is dirty: write back |
| evictReq | output | 1 | Displaced clean line goes to next level |
| forcedMiss | output | 1 | Miss forced by cacheOff |
| respHit | output | 1 | Lookup hit |

## Verification
The assertions assume that the set inputs (`wayValid`, `wayDirty`, `hitVec`, `lockMask`) are sampled only in the accepting cycle. They also assume that `wayDirty` is meaningful only where `wayValid` is set. The stimulus holds every input steady while `reqValid` is high and drops `reqValid` in the cycle after acceptance. It keeps dirty bits inside valid ways and sends one request per two cycles, so each result can be matched against a pointer position tracked by hand.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  localparam int VS_WAYS = 16;

  // control-to-datapath strobes
  typedef struct packed {
    logic accept;   // request taken this cycle
  } vselStrobe_t;
endpackage

// File: rtl/vsel_ctrl.sv
module vsel_ctrl
  import vsel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        respValid,
  output vselStrobe_t strobe
);
  logic readyReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyReg  <= 1'b0;
      respValid <= 1'b0;
    end else begin
      readyReg  <= 1'b1;
      respValid <= reqValid && readyReg;
    end
  end

  assign reqReady      = readyReg;
  assign strobe.accept = reqValid && readyReg;

  // R1
  resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> respValid);
  // R1
  resp_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !respValid);
endmodule

// File: rtl/vsel_dp.sv
module vsel_dp
  import vsel_pkg::*;
#(
  parameter  int WAYS = VS_WAYS,
  localparam int PW   = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  vselStrobe_t     strobe,
  input  logic            fillKind,
  input  logic            cacheOff,
  input  logic            evictClean,
  input  logic            keepLockedClean,
  input  logic [WAYS-1:0] lockMask,
  input  logic [WAYS-1:0] wayValid,
  input  logic [WAYS-1:0] wayDirty,
  input  logic [WAYS-1:0] hitVec,
  output logic [WAYS-1:0] victimOneHot,
  output logic            allocEn,
  output logic            wbReq,
  output logic            evictReq,
  output logic            forcedMiss,
  output logic            respHit
);
  logic [PW-1:0]   rrPtr;
  logic [WAYS-1:0] candMask, freeMask, victOh;
  logic            freeFound, rrFound;
  logic [PW-1:0]   freeIdx, rrIdx, probeIdx, victIdx, nextPtr;
  logic            anyHit, doAlloc, displaced, dirtyOut, evictNow;

  // eligible ways and first free way
  always_comb begin
    candMask  = fillKind ? lockMask : ~lockMask;
    freeMask  = candMask & ~wayValid;
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!freeFound && freeMask[i]) begin
        freeFound = 1'b1;
        freeIdx   = PW'(i);
      end
    end
  end

  // round-robin search starting at the pointer
  always_comb begin
    rrFound  = 1'b0;
    rrIdx    = '0;
    probeIdx = '0;
    for (int i = 0; i < WAYS; i++) begin
      probeIdx = PW'((int'(rrPtr) + i) % WAYS);
      if (!rrFound && candMask[probeIdx]) begin
        rrFound = 1'b1;
        rrIdx   = probeIdx;
      end
    end
  end

  // victim and displaced-line policy
  always_comb begin
    anyHit    = |hitVec;
    doAlloc   = !cacheOff && !anyHit && (|candMask);
    victIdx   = freeFound ? freeIdx : rrIdx;
    victOh    = doAlloc ? (WAYS'(1) << victIdx) : '0;
    displaced = doAlloc && !freeFound;
    dirtyOut  = displaced && wayDirty[victIdx];
    evictNow  = displaced && !wayDirty[victIdx] && evictClean &&
                !(keepLockedClean && lockMask[victIdx]);
    nextPtr   = PW'((int'(victIdx) + 1) % WAYS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr        <= '0;
      victimOneHot <= '0;
      allocEn      <= 1'b0;
      wbReq        <= 1'b0;
      evictReq     <= 1'b0;
      forcedMiss   <= 1'b0;
      respHit      <= 1'b0;
    end else if (strobe.accept) begin
      if (doAlloc) rrPtr <= nextPtr;
      victimOneHot <= victOh;
      allocEn      <= doAlloc;
      wbReq        <= dirtyOut;
      evictReq     <= evictNow;
      forcedMiss   <= cacheOff;
      respHit      <= !cacheOff && anyHit;
    end else begin
      victimOneHot <= '0;
      allocEn      <= 1'b0;
      wbReq        <= 1'b0;
      evictReq     <= 1'b0;
      forcedMiss   <= 1'b0;
      respHit      <= 1'b0;
    end
  end

  // R3
  no_locked_victim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && !fillKind) |=> ((victimOneHot & $past(lockMask)) == '0));
  // R3
  victim_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocEn |-> $onehot(victimOneHot));
  // R3
  no_victim_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !allocEn |-> (victimOneHot == '0));
  // R5
  off_forces_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && cacheOff) |=> (forcedMiss && !respHit && !allocEn && !wbReq && !evictReq));
  // R8
  wb_excludes_evict_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> !evictReq);
  // R7
  ptr_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.accept && doAlloc) |=> $stable(rrPtr));
endmodule

// File: rtl/victim_way_picker.sv
module victim_way_picker
  import vsel_pkg::*;
#(
  parameter int WAYS = VS_WAYS
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic            fillKind,
  input  logic            cacheOff,
  input  logic            evictClean,
  input  logic            keepLockedClean,
  input  logic [WAYS-1:0] lockMask,
  input  logic [WAYS-1:0] wayValid,
  input  logic [WAYS-1:0] wayDirty,
  input  logic [WAYS-1:0] hitVec,
  output logic            respValid,
  output logic            allocEn,
  output logic [WAYS-1:0] victimOneHot,
  output logic            wbReq,
  output logic            evictReq,
  output logic            forcedMiss,
  output logic            respHit
);
  vselStrobe_t strobe;

  vsel_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .respValid(respValid), .strobe(strobe)
  );

  vsel_dp #(.WAYS(WAYS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fillKind(fillKind),
    .cacheOff(cacheOff), .evictClean(evictClean), .keepLockedClean(keepLockedClean),
    .lockMask(lockMask), .wayValid(wayValid), .wayDirty(wayDirty), .hitVec(hitVec),
    .victimOneHot(victimOneHot), .allocEn(allocEn), .wbReq(wbReq),
    .evictReq(evictReq), .forcedMiss(forcedMiss), .respHit(respHit)
  );
endmodule

// File: tb/victim_way_picker_test.sv
`timescale 1ns/1ps
module victim_way_picker_test;
  typedef struct packed {
    logic        kind, off, ec, kl;
    logic [15:0] lock, valid, dirty, hit;
    logic [15:0] eOh;
    logic        eAlloc, eWb, eEv, eFm, eHit;
  } vec_t;

  localparam int NV = 19;
  // pointer after reset is 0; comments give pointer after each vector
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0, 16'h0000,16'h0000,16'h0000,16'h0000, 16'h0001,1'b1,1'b0,1'b0,1'b0,1'b0}, // R6 ptr1
    '{1'b0,1'b0,1'b0,1'b0, 16'h0003,16'h0000,16'h0000,16'h0000, 16'h0004,1'b1,1'b0,1'b0,1'b0,1'b0}, // R3 ptr3
    '{1'b0,1'b0,1'b0,1'b0, 16'h00F0,16'hFFFF,16'h0000,16'h0000, 16'h0008,1'b1,1'b0,1'b0,1'b0,1'b0}, // R9 ptr4
    '{1'b0,1'b0,1'b1,1'b0, 16'h00F0,16'hFFFF,16'h0000,16'h0000, 16'h0100,1'b1,1'b0,1'b1,1'b0,1'b0}, // R3 ptr9
    '{1'b0,1'b0,1'b1,1'b1, 16'h0000,16'hFFFF,16'hFFFF,16'h0000, 16'h0200,1'b1,1'b1,1'b0,1'b0,1'b0}, // R8 ptr10
    '{1'b0,1'b0,1'b0,1'b0, 16'h0000,16'hFFFF,16'h0000,16'h0010, 16'h0000,1'b0,1'b0,1'b0,1'b0,1'b1}, // R13
    '{1'b0,1'b0,1'b0,1'b0, 16'hFFFF,16'h0000,16'h0000,16'h0000, 16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0}, // R4
    '{1'b0,1'b0,1'b0,1'b0, 16'hFFFF,16'h0000,16'h0000,16'h0004, 16'h0000,1'b0,1'b0,1'b0,1'b0,1'b1}, // R4
    '{1'b0,1'b1,1'b0,1'b0, 16'h0000,16'h0000,16'h0000,16'h0001, 16'h0000,1'b0,1'b0,1'b0,1'b1,1'b0}, // R5
    '{1'b0,1'b0,1'b0,1'b0, 16'h0000,16'hFFFF,16'h0000,16'h0000, 16'h0400,1'b1,1'b0,1'b0,1'b0,1'b0}, // R7 ptr11
    '{1'b1,1'b0,1'b1,1'b1, 16'hF000,16'hFFFF,16'h0000,16'h0000, 16'h1000,1'b1,1'b0,1'b0,1'b0,1'b0}, // R11 ptr13
    '{1'b1,1'b0,1'b1,1'b0, 16'hF000,16'hFFFF,16'h0000,16'h0000, 16'h2000,1'b1,1'b0,1'b1,1'b0,1'b0}, // R12 ptr14
    '{1'b1,1'b0,1'b0,1'b1, 16'hF000,16'hFFFF,16'h0000,16'h0000, 16'h4000,1'b1,1'b0,1'b0,1'b0,1'b0}, // R9 ptr15
    '{1'b0,1'b0,1'b1,1'b1, 16'h00FF,16'hFFFF,16'h0000,16'h0000, 16'h8000,1'b1,1'b0,1'b1,1'b0,1'b0}, // R10 ptr0
    '{1'b0,1'b0,1'b0,1'b0, 16'h0000,16'hFFFF,16'h0001,16'h0000, 16'h0001,1'b1,1'b1,1'b0,1'b0,1'b0}, // R8 ptr1
    '{1'b1,1'b0,1'b0,1'b0, 16'h0000,16'h0000,16'h0000,16'h0000, 16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0}, // R12
    '{1'b0,1'b0,1'b0,1'b0, 16'h0002,16'hFFFD,16'h0000,16'h0000, 16'h0004,1'b1,1'b0,1'b0,1'b0,1'b0}, // R3 ptr3
    '{1'b0,1'b1,1'b1,1'b0, 16'h0000,16'hFFFF,16'hFFFF,16'h0000, 16'h0000,1'b0,1'b0,1'b0,1'b1,1'b0}, // R5
    '{1'b0,1'b0,1'b0,1'b0, 16'h0000,16'hFFFF,16'h0000,16'h0000, 16'h0008,1'b1,1'b0,1'b0,1'b0,1'b0}  // R7 ptr4
  };
  localparam string TAGS [NV] = '{"R6","R3","R9","R10","R8","R13","R4","R4","R5","R7",
                                  "R11","R12","R9","R10","R8","R12","R3","R5","R7"};

  logic clk = 1'b0, rstN = 1'b0, reqValid = 1'b0;
  logic fillKind = 1'b0, cacheOff = 1'b0, evictClean = 1'b0, keepLockedClean = 1'b0;
  logic [15:0] lockMask = '0, wayValid = '0, wayDirty = '0, hitVec = '0;
  logic reqReady, respValid, allocEn, wbReq, evictReq, forcedMiss, respHit;
  logic [15:0] victimOneHot;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  victim_way_picker uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .fillKind(fillKind), .cacheOff(cacheOff), .evictClean(evictClean),
    .keepLockedClean(keepLockedClean), .lockMask(lockMask), .wayValid(wayValid),
    .wayDirty(wayDirty), .hitVec(hitVec), .respValid(respValid), .allocEn(allocEn),
    .victimOneHot(victimOneHot), .wbReq(wbReq), .evictReq(evictReq),
    .forcedMiss(forcedMiss), .respHit(respHit)
  );

  task automatic check(input string tag, input logic [22:0] got, input logic [22:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [22:0] outsNow();
    return {reqReady, respValid, victimOneHot, allocEn, wbReq, evictReq, forcedMiss, respHit};
  endfunction

  task automatic runVec(input vec_t v, input string tag);
    @(negedge clk);
    fillKind = v.kind; cacheOff = v.off; evictClean = v.ec; keepLockedClean = v.kl;
    lockMask = v.lock; wayValid = v.valid; wayDirty = v.dirty; hitVec = v.hit;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(tag, outsNow(), {1'b1, 1'b1, v.eOh, v.eAlloc, v.eWb, v.eEv, v.eFm, v.eHit});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2", outsNow(), 23'h0);          // R2 reset: all low, not ready
    reqValid = 1'b1;
    @(negedge clk);
    check("R2", outsNow(), 23'h0);          // R2 request ignored in reset
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1", outsNow(), {1'b1, 22'h0});  // R1 ready after reset release
    for (int i = 0; i < NV; i++) runVec(VECS[i], TAGS[i]);
    @(negedge clk);
    check("R1", outsNow(), {1'b1, 22'h0});  // R1 single-cycle response, then quiet
    // R1 back-to-back accepts give a response in each following cycle
    fillKind = 1'b0; cacheOff = 1'b0; lockMask = '0; wayValid = '0; hitVec = '0;
    reqValid = 1'b1;
    @(negedge clk);
    check("R1", outsNow(), {1'b1, 1'b1, 16'h0001, 1'b1, 4'h0});
    hitVec = 16'h0100;
    @(negedge clk);
    reqValid = 1'b0;
    check("R13", outsNow(), {1'b1, 1'b1, 16'h0000, 1'b0, 3'h0, 1'b1});
    // R2 reset in the middle restores pointer to 0
    rstN = 1'b0;
    @(negedge clk);
    check("R2", outsNow(), 23'h0);
    rstN = 1'b1;
    @(negedge clk);
    runVec('{1'b0,1'b0,1'b0,1'b0, 16'h0000,16'hFFFF,16'h0000,16'h0000,
             16'h0001,1'b1,1'b0,1'b0,1'b0,1'b0}, "R2");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule